// File: doc/BRIEF.md
# Trigger Pulse Repeater with Glitch Rejection and Lockout

This block regenerates trigger pulses on one channel. It synchronises an asynchronous trigger line and rejects pulses too short to be real. For each trigger it accepts, it sends out a clean pulse of fixed width. It then refuses new triggers until a guard window has passed, so that a chattering or stuck line cannot drive the output at an unsafe rate. An indicator output, for example for a lamp driver, is high in exactly the same cycles as the regenerated pulse.

The guard window is `PULSE_LEN + LOCK_LEN` samples long. It opens on the first synchronised high sample of an accepted trigger. If the line is still high on the first sample after the window closes, the block fires again at once and opens a new window. A line held high therefore produces a steady train of pulses, one per window. A line that has dropped returns the block to idle, where a trigger must qualify again.

There is no data stream here, only level signals, so the pins carry no valid/ready handshake. The qualification pattern `MASK`, the pulse width, the lockout length and the synchroniser depth are all compile-time parameters.

Top module: `trig_repeater`

## Requirements
- R1: A synchronous active-high `rst` brings `pulse_out` and `ind_out` low on the next rising edge, even in the middle of a pulse. After reset is released, an output pulse needs a new qualified trigger.
- R2: The raw trigger passes through a two-stage synchroniser. With the default all-ones mask, when `trig_in` is first sampled high on edge E and stays high, `pulse_out` rises after edge E+7, which is the 8th edge counted from E.
- R3: A trigger qualifies only if the current synchronised sample and the earlier samples match the mask, where mask bit i stands for the sample taken i cycles earlier. With the default mask of six ones, a trigger must be high for 6 consecutive samples. An input high for 5 cycles produces no pulse.
- R4: Every output pulse is exactly `PULSE_LEN` (default 30) cycles long, whatever the width of the input.
- R5: Triggers that arrive while the block is pulsing or inside the guard window are ignored. They are not stored for later, and no pulse comes from them after the window closes.
- R6: The guard window lasts `PULSE_LEN + LOCK_LEN` (default 60) synchronised samples, counted from the first high sample of the accepted trigger. If the sample right after the window is high, a new pulse starts on that edge without going through qualification again, and it opens a new window. Input widths of 59 and 60 cycles give one pulse, 61 gives two, and 130 gives three.
- R7: `ind_out` equals `pulse_out` in every cycle.
- R8: Once a window has closed with the input low, the block is idle. A new trigger then qualifies with the normal R2 latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all logic |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Raw trigger line, asynchronous to clk |
| pulse_out | output | 1 | Regenerated fixed-width trigger pulse |
| ind_out | output | 1 | Indicator drive, high in the same cycles as pulse_out |

## Verification
The bound checker tests the following properties on every cycle:
- the pulse width against `PULSE_LEN`;
- that the indicator follows the pulse;
- that the output is cleared after reset;
- that a rising edge on the output always follows a raw high sample three edges earlier;
- the minimum spacing between pulse starts that the guard window enforces.

Some behaviour can only be shown by the bench's scenarios, where a scoreboard compares the exact start cycle of each pulse and the number of pulses per input width. These scenarios cover:
- the latency from raw input to output;
- the 5-cycle glitch that must be rejected;
- the 59/60/61-cycle boundary of re-firing;
- the long held input that must give a steady pulse train;
- a second trigger that is dropped inside the window;
- a fresh trigger once the window has closed.

// File: rtl/trig_repeater_pkg.sv
`timescale 1ns/1ps
package trig_repeater_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FIRE = 2'd1,
    ST_HOLD = 2'd2
  } rep_state_t;
endpackage

// File: rtl/trig_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for one asynchronous level.
module trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/trig_qualify.sv
`timescale 1ns/1ps
// Glitch qualifier: the history of samples (current at bit 0) must cover MASK.
module trig_qualify #(
  parameter int              MASK_W = 6,
  parameter logic [MASK_W-1:0] MASK = '1
) (
  input  logic clk,
  input  logic rst,
  input  logic sample,
  output logic qual
);
  logic [MASK_W-1:0] window;

  generate
    if (MASK_W == 1) begin : g_w1
      assign window = sample;
    end else begin : g_wn
      logic [MASK_W-2:0] hist;
      always_ff @(posedge clk) begin
        if (rst) hist <= '0;
        else     hist <= {hist[MASK_W-3 >= 0 ? MASK_W-3 : 0:0], sample};
      end
      assign window = {hist, sample};
    end
  endgenerate

  assign qual = sample && ((window & MASK) == MASK);
endmodule

// File: rtl/trig_timer.sv
`timescale 1ns/1ps
// Pulse length and guard window sequencing.
module trig_timer
  import trig_repeater_pkg::*;
#(
  parameter int PULSE_LEN = 30,
  parameter int LOCK_LEN  = 30,
  parameter int MASK_W    = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic level,
  input  logic qual,
  output logic pulse_q,
  output logic ind_q
);
  localparam int WIN = PULSE_LEN + LOCK_LEN;
  localparam int PW  = $clog2(PULSE_LEN + 1);
  localparam int WW  = $clog2(WIN + 1);

  rep_state_t    state;
  logic [PW-1:0] pcnt;
  logic [WW-1:0] wcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      pcnt    <= '0;
      wcnt    <= '0;
      pulse_q <= 1'b0;
      ind_q   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (qual) begin
            state   <= ST_FIRE;
            pcnt    <= PW'(1);
            wcnt    <= WW'(MASK_W);
            pulse_q <= 1'b1;
            ind_q   <= 1'b1;
          end
        end
        ST_FIRE: begin
          wcnt <= wcnt + 1'b1;
          if (pcnt == PW'(PULSE_LEN)) begin
            state   <= ST_HOLD;
            pulse_q <= 1'b0;
            ind_q   <= 1'b0;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        ST_HOLD: begin
          if (wcnt == WW'(WIN)) begin
            if (level) begin
              state   <= ST_FIRE;
              pcnt    <= PW'(1);
              wcnt    <= WW'(1);
              pulse_q <= 1'b1;
              ind_q   <= 1'b1;
            end else begin
              state <= ST_IDLE;
              wcnt  <= '0;
            end
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/trig_repeater.sv
`timescale 1ns/1ps
module trig_repeater #(
  parameter int                PULSE_LEN   = 30,
  parameter int                LOCK_LEN    = 30,
  parameter int                MASK_W      = 6,
  parameter logic [MASK_W-1:0] MASK        = '1,
  parameter int                SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_in,
  output logic pulse_out,
  output logic ind_out
);
  logic s_level;
  logic s_qual;

  trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (trig_in),
    .q   (s_level)
  );

  trig_qualify #(.MASK_W(MASK_W), .MASK(MASK)) u_qual (
    .clk    (clk),
    .rst    (rst),
    .sample (s_level),
    .qual   (s_qual)
  );

  trig_timer #(.PULSE_LEN(PULSE_LEN), .LOCK_LEN(LOCK_LEN), .MASK_W(MASK_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .level   (s_level),
    .qual    (s_qual),
    .pulse_q (pulse_out),
    .ind_q   (ind_out)
  );
endmodule

// File: rtl/trig_repeater_check.sv
`timescale 1ns/1ps
module trig_repeater_check #(
  parameter int PULSE_LEN = 30,
  parameter int LOCK_LEN  = 30,
  parameter int MASK_W    = 6
) (
  input logic clk,
  input logic rst,
  input logic trig_in,
  input logic pulse_out,
  input logic ind_out
);
  localparam int MIN_GAP = PULSE_LEN + LOCK_LEN - MASK_W + 1;
  localparam int CW      = $clog2(PULSE_LEN + LOCK_LEN + 2) + 1;

  logic [CW-1:0] hi_cnt;
  logic [CW-1:0] gap_cnt;
  logic          seen_rise;
  logic          prev_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt    <= '0;
      gap_cnt   <= '0;
      seen_rise <= 1'b0;
      prev_out  <= 1'b0;
    end else begin
      prev_out <= pulse_out;
      hi_cnt   <= pulse_out ? hi_cnt + 1'b1 : '0;
      if (pulse_out && !prev_out) begin
        gap_cnt   <= CW'(1);
        seen_rise <= 1'b1;
      end else if (gap_cnt != '1) begin
        gap_cnt <= gap_cnt + 1'b1;
      end
    end
  end

  // R1
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (!pulse_out && !ind_out));

  // R7
  p_ind_follows_r7: assert property (@(posedge clk) disable iff (rst)
    ind_out == pulse_out);

  // R4
  p_width_cap_r4: assert property (@(posedge clk) disable iff (rst)
    pulse_out |-> (hi_cnt < CW'(PULSE_LEN)));

  // R4
  p_width_exact_r4: assert property (@(posedge clk) disable iff (rst)
    (prev_out && !pulse_out) |-> (hi_cnt == CW'(PULSE_LEN)));

  // R2
  p_rise_needs_input_r2: assert property (@(posedge clk) disable iff (rst)
    (pulse_out && !prev_out) |-> $past(trig_in, 3));

  // R5
  p_guard_spacing_r5: assert property (@(posedge clk) disable iff (rst)
    (pulse_out && !prev_out && seen_rise) |-> (gap_cnt >= CW'(MIN_GAP)));
endmodule

bind trig_repeater trig_repeater_check #(
  .PULSE_LEN (PULSE_LEN),
  .LOCK_LEN  (LOCK_LEN),
  .MASK_W    (MASK_W)
) u_check (
  .clk       (clk),
  .rst       (rst),
  .trig_in   (trig_in),
  .pulse_out (pulse_out),
  .ind_out   (ind_out)
);

// File: tb/trig_repeater_test.sv
`timescale 1ns/1ps
module trig_repeater_test;
  localparam int PL  = 30;
  localparam int LL  = 30;
  localparam int MW  = 6;
  localparam int WIN = PL + LL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig_in = 1'b0;
  logic pulse_out;
  logic ind_out;

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  int    exp_q[$];
  bit    done = 0;

  trig_repeater uut (
    .clk       (clk),
    .rst       (rst),
    .trig_in   (trig_in),
    .pulse_out (pulse_out),
    .ind_out   (ind_out)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Monitor: pops the scoreboard on each completed pulse.
  bit in_p = 0;
  bit ind_bad = 0;
  int rise_c = 0;
  always @(negedge clk) begin
    if (rst) begin
      in_p = 0;
      ind_bad = 0;
    end else begin
      if (pulse_out !== ind_out) ind_bad = 1;
      if (pulse_out && !in_p) begin
        in_p = 1;
        rise_c = cyc;
      end else if (!pulse_out && in_p) begin
        int width;
        int e;
        in_p = 0;
        width = cyc - rise_c;
        if (exp_q.size() == 0) begin
          chk(0, cur_req, "unexpected pulse start", rise_c, -1);
        end else begin
          e = exp_q.pop_front();
          chk(rise_c == e, cur_req, "pulse start cycle", rise_c, e);
        end
        chk(width == PL, "R4", "pulse width", width, PL);
        chk(!ind_bad, "R7", "indicator mismatch", ind_bad, 0);
        ind_bad = 0;
      end
    end
  end

  // Driver: pushes the expected pulse starts, then drives n high cycles.
  task automatic run_trig(input int n);
    int c0;
    @(negedge clk);
    c0 = cyc;
    if (n >= MW) begin
      exp_q.push_back(c0 + MW + 2);
      for (int k = 1; WIN * k <= n - 1; k++) exp_q.push_back(c0 + 3 + WIN * k);
    end
    trig_in = 1'b1;
    repeat (n) @(negedge clk);
    trig_in = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic close_scn();
    idle(100);
    chk(exp_q.size() == 0, cur_req, "pulses still expected", exp_q.size(), 0);
  endtask

  initial begin
    #(8 * 150000);
    chk(0, cur_req, "watchdog expired", cyc, 0);
    if (!done) begin
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    idle(4);
    chk(pulse_out == 1'b0, "R1", "pulse_out in reset", pulse_out, 0);
    chk(ind_out == 1'b0, "R1", "ind_out in reset", ind_out, 0);
    rst = 1'b0;
    idle(5);

    // R2: normal 20-cycle trigger, one pulse at the expected latency
    cur_req = "R2";
    run_trig(20);
    close_scn();

    // R3: 5-cycle glitch is rejected
    cur_req = "R3";
    run_trig(5);
    close_scn();

    // R6: boundary and long held inputs
    cur_req = "R6";
    run_trig(59);
    close_scn();
    run_trig(60);
    close_scn();
    run_trig(61);
    close_scn();
    run_trig(130);
    close_scn();

    // R5: second trigger inside the guard window is dropped, not queued
    cur_req = "R5";
    run_trig(20);
    idle(9);
    trig_in = 1'b1;
    idle(20);
    trig_in = 1'b0;
    close_scn();

    // R8: fresh trigger right after a window closed with the input low
    cur_req = "R8";
    run_trig(20);
    idle(49);
    run_trig(10);
    close_scn();

    // R1: reset in the middle of a pulse
    cur_req = "R1";
    @(negedge clk);
    trig_in = 1'b1;
    idle(12);
    chk(pulse_out == 1'b1, "R1", "pulse active before reset", pulse_out, 1);
    rst = 1'b1;
    trig_in = 1'b0;
    idle(1);
    chk(pulse_out == 1'b0 && ind_out == 1'b0, "R1", "outputs after mid-pulse reset",
        pulse_out, 0);
    rst = 1'b0;
    idle(60);
    chk(exp_q.size() == 0, "R1", "no pulse after reset release", exp_q.size(), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule